// File: doc/BRIEF.md
# Multi-Mode Read Sequencer

This block is the read side of a memory device. A host raises a read strobe and presents a word address. The block then fetches words from an internal array model and returns each word with a one-cycle valid flag. The way words come back depends on a small configuration register that can only be written while the engine is idle. There are three modes.

- **Random (asynchronous-style) mode:** every word waits the full initial latency.
- **Page mode:** a word that stays inside the same page as the previous one comes back after a short fixed latency.
- **Burst mode:** after one initial wait, a wrapped block of 4 or 8 words streams out at one word per clock.

All latencies are counted in cycles of one clock. Dropping the strobe ends any transfer at once. The host can change the address between words in random and page modes. In burst mode the block generates the addresses itself.

Top module: `mrd_engine`

## Requirements
- R1: After reset, `rd_valid` and `busy` are 0, and the configuration is random mode, 4-word bursts and an initial latency of RST_LAT (4) cycles.
- R2: Random mode (`cfg_mode` 2'b00). The address is captured at the first clock edge that sees `rd_req` high while idle. Each word is presented (`rd_valid`=1) exactly L edges after its address was captured, where L is the configured latency. At the edge that delivers a word, `rd_addr` is captured for the next word.
- R3: Page mode (`cfg_mode` 2'b01). When the next address has the same bits [AW-1:3] as the word just delivered, that next word follows PAGE_LAT (2) edges after the delivery.
- R4: Page mode. The first word, and any word whose bits [AW-1:3] differ from the previous word, takes the full L edges.
- R5: Burst mode (`cfg_mode` 2'b10). The first word appears L edges after capture. Each later word appears on the next edge. After exactly 4 words (`cfg_blen8`=0) or 8 words (`cfg_blen8`=1), no further word appears and `busy` stays 1 until `rd_req` is dropped.
- R6: Burst addresses increment and wrap inside the aligned block of the burst length. The low 2 bits wrap for 4-word bursts and the low 3 bits wrap for 8-word bursts. The upper bits do not change.
- R7: When `rd_req` is low at a clock edge during a transfer, `busy` is 0 and `rd_valid` is 0 after that edge, and no further word appears.
- R8: A configuration write (`cfg_we`) is taken only when `busy` is 0 and `rd_req` is 0 at the edge. Otherwise the write is ignored.
- R9: A configuration write with `cfg_mode`=2'b11 or `cfg_lat`=0 is ignored as a whole.
- R10: The array model returns, for word address A, the value {8'h00, A} XOR 16'h5A3C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode to write: 00 random, 01 page, 10 burst |
| cfg_blen8 | input | 1 | Burst length to write: 0 gives 4 words, 1 gives 8 words |
| cfg_lat | input | LW (4) | Initial latency in cycles to write (must be nonzero) |
| rd_req | input | 1 | Read strobe, held high for the whole transfer |
| rd_addr | input | AW (8) | Word address |
| rd_data | output | DW (16) | Returned word, meaningful while rd_valid is 1 |
| rd_valid | output | 1 | One-cycle flag per returned word |
| busy | output | 1 | A transfer is in progress or a finished burst is waiting for the strobe to drop |

## Verification
Every result is due a fixed number of edges after a stimulus. The first word comes L edges after the capture edge. A page-hit word comes 2 edges after the previous word. A burst word comes 1 edge after the previous one. The stop after an abort comes 1 edge after the strobe drops. The bench drives inputs and samples outputs on falling edges. It builds a per-cycle table of expected valid flags and addresses, indexed by edges since capture. At every cycle it compares both the presence and the absence of a word against that table. Addresses for the next word are changed one cycle before the delivering edge, so each capture lands where R2 places it. Ignored configuration writes are detected through the latency and addressing pattern of a later read.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  typedef enum logic [1:0] {
    MD_RAND  = 2'b00,
    MD_PAGE  = 2'b01,
    MD_BURST = 2'b10
  } mrd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_DONE = 2'b10
  } mrd_state_e;
endpackage

// File: rtl/mrd_cfg.sv
module mrd_cfg
  import mrd_pkg::*;
#(
  parameter int LW      = 4,
  parameter int RST_LAT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle_i,
  input  logic            wr_en,
  input  logic [1:0]      wr_mode,
  input  logic            wr_blen8,
  input  logic [LW-1:0]   wr_lat,
  output mrd_mode_e       mode_o,
  output logic            blen8_o,
  output logic [LW-1:0]   lat_o
);
  logic      accept;
  mrd_mode_e mode_d, mode_q;
  logic      blen8_d, blen8_q;
  logic [LW-1:0] lat_d, lat_q;

  always_comb begin
    accept  = wr_en && idle_i && (wr_mode != 2'b11) && (wr_lat != '0);
    mode_d  = mrd_mode_e'(wr_mode);
    blen8_d = wr_blen8;
    lat_d   = wr_lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_RAND;
      blen8_q <= 1'b0;
      lat_q   <= LW'(RST_LAT);
    end else if (accept) begin
      mode_q  <= mode_d;
      blen8_q <= blen8_d;
      lat_q   <= lat_d;
    end
  end

  assign mode_o  = mode_q;
  assign blen8_o = blen8_q;
  assign lat_o   = lat_q;

  // R8: configuration frozen whenever the engine is not idle with strobe low
  assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> ($stable(mode_q) && $stable(blen8_q) && $stable(lat_q)));

  // R9: illegal contents never reach the register
  assert_cfg_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_mode == 2'b11 || wr_lat == '0)) |=>
      ($stable(mode_q) && $stable(lat_q)));
endmodule

// File: rtl/mrd_array.sv
module mrd_array #(
  parameter int          AW  = 8,
  parameter int          DW  = 16,
  parameter logic [15:0] KEY = 16'h5A3C
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata
);
  always_comb rdata = DW'(addr) ^ DW'(KEY);
endmodule

// File: rtl/mrd_seq.sv
module mrd_seq
  import mrd_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int LW       = 4,
  parameter int PGB      = 3,
  parameter int PAGE_LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_req,
  input  logic [AW-1:0]   rd_addr,
  input  mrd_mode_e       mode,
  input  logic            blen8,
  input  logic [LW-1:0]   lat,
  input  logic [DW-1:0]   rdata,
  output logic [AW-1:0]   fetch_addr,
  output logic [DW-1:0]   dout,
  output logic            dvalid,
  output logic            busy
);
  localparam int BOB = 3;
  localparam logic [LW-1:0] PL = LW'(PAGE_LAT);

  mrd_state_e state_q, state_d;
  logic [LW-1:0]  cnt_q, cnt_d;
  logic [AW-1:0]  addr_q, addr_d, addr_nb;
  logic [BOB-1:0] wcnt_q, wcnt_d, wmask, low_inc;
  logic           dv_q, dv_d, fire, last_word, page_hit;
  logic [DW-1:0]  dout_q;

  always_comb begin
    fire      = (state_q == ST_WAIT) && rd_req && (cnt_q == LW'(1));
    wmask     = blen8 ? 3'b111 : 3'b011;
    low_inc   = addr_q[BOB-1:0] + 3'd1;
    addr_nb   = {addr_q[AW-1:BOB], (addr_q[BOB-1:0] & ~wmask) | (low_inc & wmask)};
    last_word = (mode == MD_BURST) && (wcnt_q == wmask);
    page_hit  = rd_addr[AW-1:PGB] == addr_q[AW-1:PGB];
    state_d = state_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    wcnt_d  = wcnt_q;
    dv_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (rd_req) begin
        state_d = ST_WAIT;
        cnt_d   = lat;
        addr_d  = rd_addr;
        wcnt_d  = '0;
      end
      ST_WAIT: begin
        if (!rd_req) begin
          state_d = ST_IDLE;
        end else if (fire) begin
          dv_d = 1'b1;
          unique case (mode)
            MD_BURST: begin
              if (last_word) state_d = ST_DONE;
              addr_d = addr_nb;
              cnt_d  = LW'(1);
              wcnt_d = wcnt_q + 3'd1;
            end
            MD_PAGE: begin
              addr_d = rd_addr;
              cnt_d  = page_hit ? PL : lat;
            end
            default: begin
              addr_d = rd_addr;
              cnt_d  = lat;
            end
          endcase
        end else begin
          cnt_d = cnt_q - LW'(1);
        end
      end
      ST_DONE: if (!rd_req) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wcnt_q  <= '0;
      dv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      wcnt_q  <= wcnt_d;
      dv_q    <= dv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout_q <= '0;
    else if (dv_d) dout_q <= rdata;
  end

  assign fetch_addr = addr_q;
  assign dout       = dout_q;
  assign dvalid     = dv_q;
  assign busy       = (state_q != ST_IDLE);

  // R7: dropped strobe during a transfer returns to idle silently
  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !rd_req) |=> (state_q == ST_IDLE && !dv_q));

  // R2: a word only ever follows a waiting cycle
  assert_valid_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dv_q |-> ($past(state_q) == ST_WAIT));

  // R2: the latency counter never idles at zero while waiting
  assert_cnt_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (cnt_q != '0));

  // R6: burst stays inside its aligned block
  assert_burst_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && $past(state_q) == ST_WAIT && mode == MD_BURST) |->
      (addr_q[AW-1:BOB] == $past(addr_q[AW-1:BOB]) &&
       (blen8 || addr_q[2] == $past(addr_q[2]))));

  // R5: nothing is delivered once a burst has completed
  assert_burst_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_DONE) |-> !dv_q);
endmodule

// File: rtl/mrd_engine.sv
module mrd_engine
  import mrd_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int LW       = 4,
  parameter int PGB      = 3,
  parameter int PAGE_LAT = 2,
  parameter int RST_LAT  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_blen8,
  input  logic [LW-1:0] cfg_lat,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          busy
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  mrd_mode_e     mode;
  logic          blen8;
  logic [LW-1:0] lat;
  logic [AW-1:0] fetch_addr;
  logic [DW-1:0] rdata;
  logic          busy_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  mrd_cfg #(.LW(LW), .RST_LAT(RST_LAT)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .idle_i(!busy_w && !rd_req),
    .wr_en(cfg_we), .wr_mode(cfg_mode), .wr_blen8(cfg_blen8), .wr_lat(cfg_lat),
    .mode_o(mode), .blen8_o(blen8), .lat_o(lat)
  );

  mrd_array #(.AW(AW), .DW(DW)) u_array (
    .addr(fetch_addr), .rdata(rdata)
  );

  mrd_seq #(.AW(AW), .DW(DW), .LW(LW), .PGB(PGB), .PAGE_LAT(PAGE_LAT)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .mode(mode), .blen8(blen8), .lat(lat), .rdata(rdata),
    .fetch_addr(fetch_addr), .dout(rd_data), .dvalid(rd_valid), .busy(busy_w)
  );

  assign busy = busy_w;
endmodule

// File: tb/mrd_engine_bench.sv
module mrd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_blen8 = 1'b0;
  logic [3:0]  cfg_lat = 4'd4;
  logic        rd_req = 1'b0;
  logic [7:0]  rd_addr = 8'h00;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic       ev  [0:31];
  logic [7:0] ea  [0:31];
  logic       hc  [0:31];
  logic [7:0] ca  [0:31];

  always #10 clk = ~clk;

  mrd_engine u_mrd_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_blen8(cfg_blen8), .cfg_lat(cfg_lat), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
  );

  function automatic logic [15:0] word_of(input logic [7:0] a);
    return {8'h00, a} ^ 16'h5A3C;  // R10
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_exp();
    for (int i = 0; i < 32; i++) begin
      ev[i] = 1'b0; ea[i] = 8'h00; hc[i] = 1'b0; ca[i] = 8'h00;
    end
  endtask

  task automatic cfg_write(input logic [1:0] m, input logic b8, input logic [3:0] l);
    cfg_we = 1'b1; cfg_mode = m; cfg_blen8 = b8; cfg_lat = l;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start(input logic [7:0] a);
    rd_req = 1'b1; rd_addr = a;
    @(posedge clk);
  endtask

  task automatic observe(input int kmax, input string req);
    for (int k = 1; k <= kmax; k++) begin
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
      check(rd_valid == ev[k], req, $sformatf("valid at edge %0d", k), rd_valid, ev[k]);
      if (ev[k] && rd_valid)
        check(rd_data == word_of(ea[k]), req, $sformatf("data at edge %0d", k),
              rd_data, word_of(ea[k]));
      if (hc[k]) rd_addr = ca[k];
    end
  endtask

  task automatic stop(input string req);
    rd_req = 1'b0;
    @(posedge clk); @(negedge clk);
    check(!busy, req, "busy after strobe drop", busy, 0);
    check(!rd_valid, req, "valid after strobe drop", rd_valid, 0);
    @(posedge clk); @(negedge clk);
    check(!rd_valid, req, "valid one edge later", rd_valid, 0);
  endtask

  task automatic t_reset();
    check(!busy, "R1", "busy after reset", busy, 0);
    check(!rd_valid, "R1", "valid after reset", rd_valid, 0);
  endtask

  task automatic t_random();  // R2 with reset latency 4 (R1)
    clear_exp();
    ev[4] = 1; ea[4] = 8'h10; hc[3] = 1; ca[3] = 8'h33;
    ev[8] = 1; ea[8] = 8'h33;
    start(8'h10); observe(9, "R2"); stop("R2");
  endtask

  task automatic t_page();  // R3 R4
    cfg_write(2'b01, 1'b0, 4'd5);
    clear_exp();
    ev[5]  = 1; ea[5]  = 8'h20; hc[4]  = 1; ca[4]  = 8'h23;
    ev[7]  = 1; ea[7]  = 8'h23; hc[6]  = 1; ca[6]  = 8'h48;
    ev[12] = 1; ea[12] = 8'h48; hc[11] = 1; ca[11] = 8'h49;
    ev[14] = 1; ea[14] = 8'h49;
    start(8'h20); observe(15, "R3_R4"); stop("R4");
  endtask

  task automatic t_burst4();  // R5 R6
    cfg_write(2'b10, 1'b0, 4'd3);
    clear_exp();
    ev[3] = 1; ea[3] = 8'h46; ev[4] = 1; ea[4] = 8'h47;
    ev[5] = 1; ea[5] = 8'h44; ev[6] = 1; ea[6] = 8'h45;
    start(8'h46); observe(9, "R5_R6");
    check(busy, "R5", "busy held after burst", busy, 1);
    stop("R5");
  endtask

  task automatic t_burst8(input logic [7:0] a, input string req);  // R5 R6
    clear_exp();
    for (int i = 0; i < 8; i++) begin
      ev[6+i] = 1; ea[6+i] = {a[7:3], 3'(a[2:0] + 3'(i))};
    end
    start(a); observe(16, req);
    check(busy, req, "busy held after 8-word burst", busy, 1);
    stop(req);
  endtask

  task automatic t_abort();  // R7
    clear_exp();
    ev[6] = 1; ea[6] = 8'h00; ev[7] = 1; ea[7] = 8'h01;
    start(8'h00); observe(7, "R7"); stop("R7");
  endtask

  task automatic t_locked();  // R8
    clear_exp();
    start(8'h50); observe(2, "R8");
    cfg_we = 1'b1; cfg_mode = 2'b00; cfg_blen8 = 1'b0; cfg_lat = 4'd2;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    stop("R8");
    cfg_we = 1'b1; cfg_mode = 2'b00; cfg_blen8 = 1'b0; cfg_lat = 4'd2;
    t_burst8(8'h60, "R8");
  endtask

  task automatic t_illegal();  // R9
    cfg_write(2'b11, 1'b0, 4'd2);
    cfg_write(2'b00, 1'b0, 4'd0);
    t_burst8(8'h07, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_random();
    t_page();
    t_burst4();
    cfg_write(2'b10, 1'b1, 4'd6);
    t_burst8(8'h9D, "R6");
    t_abort();
    t_locked();
    t_illegal();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule